// File: doc/BRIEF.md
# Dual Interrupt Status and Mask Aggregator

This block gathers single-cycle interrupt request pulses from two source groups, a general group and a DMA-channel group. Each source has a sticky status bit. Each group also has a mask, and the block drives one cause line per group toward the processor. The general cause comes with code 0x400 and the DMA cause with code 0x800. The processor can watch the two lines separately.

Software uses a small register window for three things:
- reading the status and mask of both groups;
- clearing status bits by writing ones to them;
- flipping mask bits by writing ones to them.

The DMA group keeps its status and its mask in a single 32-bit word. One DMA source can never be masked off. The whole DMA cause is gated by an external global DMA enable and by an external suspend field.

When the general cause begins while general status bit 1 is set, the block latches the current counts of two external timers. It also pulses a strobe so that neighbouring logic knows a fresh snapshot exists.

Top module: `irq_aggregator`

## Requirements
- R1: A one-cycle pulse on request input n sets status bit n at the next clock edge. General status reads back at register address 0, bits [15:0]. DMA status reads back at address 2, bits [15:0].
- R2: A status bit stays set until a write of 1 to that bit clears it. General status is cleared through address 0. DMA status is cleared through bits [15:0] of address 2. Written zeros leave status unchanged.
- R3: When a request and a clear hit the same status bit in the same cycle, the request wins and the bit is set after the edge. Other cleared bits are still cleared.
- R4: Writing 1 to a mask bit inverts it. The general mask is at address 1, bits [15:0], and reads back there. The DMA mask is at address 2, bits [31:16], and reads back there.
- R5: `gen_cause` is 1 and `gen_code` is 0x400 exactly when general status AND general mask is nonzero. Otherwise `gen_cause` is 0 and `gen_code` is 0, even if status is nonzero.
- R6: A DMA request is pending when DMA status AND DMA mask is nonzero, or when DMA status bit 15 is set whatever the state of mask bit 15. In that case `dma_cause` is 1 and `dma_code` is 0x800; otherwise both are 0.
- R7: The DMA cause and code are forced to 0 while `dma_enable` is 0 or `dma_suspend` equals 1. Any other suspend value lets the pending DMA request through. The DMA status is retained meanwhile.
- R8: At the first clock edge where `gen_cause` has gone from 0 to 1 with general status bit 1 set, `hold0` and `hold1` load `tmr0_count` and `tmr1_count`. At that edge `hold_strobe` goes high for one cycle. The hold values do not change at any other time.
- R9: After reset every status and mask bit is 0, both causes and codes are 0, the hold outputs are 0, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_req | input | 16 | General source request pulses, one bit per source |
| dma_req | input | 16 | DMA channel request pulses, one bit per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from address |
| dma_enable | input | 1 | Global DMA enable |
| dma_suspend | input | 8 | Suspend field; value 1 suppresses the DMA cause |
| tmr0_count | input | 16 | Current count of timer 0 |
| tmr1_count | input | 16 | Current count of timer 1 |
| gen_cause | output | 1 | General interrupt cause |
| gen_code | output | 12 | 0x400 when gen_cause is high, else 0 |
| dma_cause | output | 1 | DMA interrupt cause |
| dma_code | output | 12 | 0x800 when dma_cause is high, else 0 |
| hold_strobe | output | 1 | One-cycle pulse when the timer snapshot is taken |
| hold0 | output | 16 | Snapshot of timer 0 |
| hold1 | output | 16 | Snapshot of timer 1 |

## Verification
A hardware request and a software clear can land on the same status bit in the same cycle. The bench provokes this in both groups by holding a request pulse high during the very cycle that carries a clearing write. In one case the write also covers a second bit that has no request. Reading the status back afterwards must show that the requested bit survived and that the unrequested bit was cleared.

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int GEN_W  = 16,
  parameter int DMA_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SUSP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GEN_W-1:0]  gen_req,
  input  logic [DMA_W-1:0]  dma_req,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dma_enable,
  input  logic [SUSP_W-1:0] dma_suspend,
  input  logic [CNT_W-1:0]  tmr0_count,
  input  logic [CNT_W-1:0]  tmr1_count,
  output logic              gen_cause,
  output logic [11:0]       gen_code,
  output logic              dma_cause,
  output logic [11:0]       dma_code,
  output logic              hold_strobe,
  output logic [CNT_W-1:0]  hold0,
  output logic [CNT_W-1:0]  hold1
);
  localparam int          LOCK_BIT = DMA_W - 1;
  localparam logic [11:0] GEN_VEC  = 12'h400;
  localparam logic [11:0] DMA_VEC  = 12'h800;

  logic [GEN_W-1:0] gen_stat, gen_mask, gen_clr, gen_tog;
  logic [DMA_W-1:0] dma_stat, dma_mask, dma_clr, dma_tog;
  logic             gen_seen, dma_pend, dma_open, snap;

  assign gen_clr = (reg_we && reg_addr == 2'd0) ? reg_wdata[GEN_W-1:0] : '0;
  assign gen_tog = (reg_we && reg_addr == 2'd1) ? reg_wdata[GEN_W-1:0] : '0;
  assign dma_clr = (reg_we && reg_addr == 2'd2) ? reg_wdata[DMA_W-1:0] : '0;
  assign dma_tog = (reg_we && reg_addr == 2'd2) ? reg_wdata[16 +: DMA_W] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_stat <= '0;
      gen_mask <= '0;
      dma_stat <= '0;
      dma_mask <= '0;
    end else begin
      gen_stat <= (gen_stat & ~gen_clr) | gen_req;
      gen_mask <= gen_mask ^ gen_tog;
      dma_stat <= (dma_stat & ~dma_clr) | dma_req;
      dma_mask <= dma_mask ^ dma_tog;
    end
  end

  assign gen_cause = |(gen_stat & gen_mask);
  assign gen_code  = gen_cause ? GEN_VEC : 12'h000;

  assign dma_pend  = (|(dma_stat & dma_mask)) | dma_stat[LOCK_BIT];
  assign dma_open  = dma_enable && (dma_suspend != SUSP_W'(1));
  assign dma_cause = dma_pend && dma_open;
  assign dma_code  = dma_cause ? DMA_VEC : 12'h000;

  assign snap = gen_cause && !gen_seen && gen_stat[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_seen    <= 1'b0;
      hold_strobe <= 1'b0;
      hold0       <= '0;
      hold1       <= '0;
    end else begin
      gen_seen    <= gen_cause;
      hold_strobe <= snap;
      if (snap) begin
        hold0 <= tmr0_count;
        hold1 <= tmr1_count;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[GEN_W-1:0] = gen_stat;
      2'd1: reg_rdata[GEN_W-1:0] = gen_mask;
      2'd2: begin
        reg_rdata[DMA_W-1:0]  = dma_stat;
        reg_rdata[16 +: DMA_W] = dma_mask;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int GEN_W  = 16,
  parameter int DMA_W  = 16,
  parameter int CNT_W  = 16,
  parameter int SUSP_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GEN_W-1:0]  gen_req,
  input logic [DMA_W-1:0]  dma_req,
  input logic              reg_we,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              dma_enable,
  input logic [SUSP_W-1:0] dma_suspend,
  input logic [CNT_W-1:0]  tmr0_count,
  input logic [CNT_W-1:0]  tmr1_count,
  input logic              gen_cause,
  input logic              dma_cause,
  input logic              hold_strobe,
  input logic [CNT_W-1:0]  hold0,
  input logic [CNT_W-1:0]  hold1,
  input logic [GEN_W-1:0]  gen_stat,
  input logic [GEN_W-1:0]  gen_mask,
  input logic [DMA_W-1:0]  dma_stat,
  input logic [DMA_W-1:0]  dma_mask
);
  logic [GEN_W-1:0] g_wipe;
  logic [DMA_W-1:0] d_wipe;
  logic             g_flip;
  logic             d_wr;

  assign g_wipe = (reg_we && reg_addr == 2'd0) ? reg_wdata[GEN_W-1:0] : '0;
  assign d_wr   = reg_we && reg_addr == 2'd2;
  assign d_wipe = d_wr ? reg_wdata[DMA_W-1:0] : '0;
  assign g_flip = reg_we && reg_addr == 2'd1;

  p_req_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gen_stat & $past(gen_req)) == $past(gen_req)) &&
             ((dma_stat & $past(dma_req)) == $past(dma_req)));

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((gen_stat & $past(gen_stat & ~g_wipe)) == $past(gen_stat & ~g_wipe)) &&
             ((dma_stat & $past(dma_stat & ~d_wipe)) == $past(dma_stat & ~d_wipe)));

  p_req_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|(g_wipe & gen_req)) |=> ((gen_stat & $past(g_wipe & gen_req)) == $past(g_wipe & gen_req)));

  p_mask_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    g_flip |=> gen_mask == $past(gen_mask ^ reg_wdata[GEN_W-1:0]));

  p_dma_mask_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr |=> dma_mask == $past(dma_mask ^ reg_wdata[16 +: DMA_W]));

  p_gen_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((gen_stat & gen_mask) == '0) |-> !gen_cause);

  p_dma_unmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_stat[DMA_W-1] && dma_enable && dma_suspend != SUSP_W'(1)) |-> dma_cause);

  p_dma_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_enable || dma_suspend == SUSP_W'(1)) |-> !dma_cause);

  p_hold_take_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |-> (hold0 == $past(tmr0_count)) && (hold1 == $past(tmr1_count)));

  p_hold_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_strobe |-> $stable(hold0) && $stable(hold1));

  p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_strobe |=> !hold_strobe);
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .GEN_W(GEN_W), .DMA_W(DMA_W), .CNT_W(CNT_W), .SUSP_W(SUSP_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .dma_req(dma_req),
  .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .dma_enable(dma_enable), .dma_suspend(dma_suspend),
  .tmr0_count(tmr0_count), .tmr1_count(tmr1_count),
  .gen_cause(gen_cause), .dma_cause(dma_cause), .hold_strobe(hold_strobe),
  .hold0(hold0), .hold1(hold1),
  .gen_stat(gen_stat), .gen_mask(gen_mask), .dma_stat(dma_stat), .dma_mask(dma_mask)
);

// File: tb/irq_aggregator_bench.sv
`timescale 1ns/1ps
module irq_aggregator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] gen_req = '0, dma_req = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dma_enable = 1'b0;
  logic [7:0]  dma_suspend = '0;
  logic [15:0] tmr0_count = '0, tmr1_count = '0;
  logic        gen_cause, dma_cause, hold_strobe;
  logic [11:0] gen_code, dma_code;
  logic [15:0] hold0, hold1;

  always #2.5 clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .gen_req(gen_req), .dma_req(dma_req),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dma_enable(dma_enable), .dma_suspend(dma_suspend),
    .tmr0_count(tmr0_count), .tmr1_count(tmr1_count),
    .gen_cause(gen_cause), .gen_code(gen_code), .dma_cause(dma_cause), .dma_code(dma_code),
    .hold_strobe(hold_strobe), .hold0(hold0), .hold1(hold1)
  );

  typedef enum logic [2:0] {K_RD, K_GCODE, K_DCODE, K_H0, K_H1, K_STB, K_GC, K_DC} kind_t;
  kind_t       kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          total = 0, failed = 0;
  bit          done = 0;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(kind_t k, logic [31:0] v, string tag);
    kind_q.push_back(k);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  task automatic rd(logic [1:0] a, logic [31:0] v, string tag);
    reg_addr = a;
    expect_out(K_RD, v, tag);
    step();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic look(string tag);
    step();
    if (tag.len() == 0) $display("idle");
  endtask

  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      kind_t       k;
      logic [31:0] e, a;
      string       t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        K_RD:    a = reg_rdata;
        K_GCODE: a = {20'd0, gen_code};
        K_DCODE: a = {20'd0, dma_code};
        K_H0:    a = {16'd0, hold0};
        K_H1:    a = {16'd0, hold1};
        K_STB:   a = {31'd0, hold_strobe};
        K_GC:    a = {31'd0, gen_cause};
        default: a = {31'd0, dma_cause};
      endcase
      total++;
      if (a !== e) begin
        failed++;
        $display("FAIL %s kind %0d actual %h expected %h", t, k, a, e);
      end
    end
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      total++; failed++;
      $display("FAIL watchdog actual running expected finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R9 reset state
    expect_out(K_GCODE, 0, "R9 gen_code");
    expect_out(K_DCODE, 0, "R9 dma_code");
    expect_out(K_STB, 0, "R9 strobe");
    expect_out(K_H0, 0, "R9 hold0");
    rd(2'd0, 0, "R9 gen status");
    rd(2'd1, 0, "R9 gen mask");
    rd(2'd2, 0, "R9 dma word");
    rd(2'd3, 0, "R9 addr3");

    // R1 request sets status, masked so no cause (R5)
    gen_req = 16'h0005; step(); gen_req = '0;
    rd(2'd0, 32'h5, "R1 gen status");
    expect_out(K_GCODE, 0, "R5 masked status");
    step();

    // R4 mask toggle, R5 cause
    wr(2'd1, 32'h4);
    rd(2'd1, 32'h4, "R4 gen mask");
    expect_out(K_GCODE, 32'h400, "R5 gen code");
    expect_out(K_GC, 1, "R5 gen cause");
    expect_out(K_STB, 0, "R8 no snap without bit1");
    step();
    wr(2'd1, 32'h6);
    rd(2'd1, 32'h2, "R4 gen mask toggled");
    expect_out(K_GCODE, 0, "R5 no enabled bit");
    expect_out(K_GC, 0, "R5 no enabled cause");
    step();

    // R2 write one to clear, zero leaves
    wr(2'd0, 32'h1);
    rd(2'd0, 32'h4, "R2 cleared bit0");
    wr(2'd0, 32'h0);
    rd(2'd0, 32'h4, "R2 zero write");

    // R3 request wins over clear
    gen_req = 16'h0001; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h5;
    step();
    gen_req = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(2'd0, 32'h1, "R3 gen req wins, other cleared");
    gen_req = 16'h0001; reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 32'h1;
    step();
    gen_req = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(2'd0, 32'h1, "R3 gen same bit");

    // R8 timer snapshot
    tmr0_count = 16'h1234; tmr1_count = 16'hABCD;
    gen_req = 16'h0002; step(); gen_req = '0;
    expect_out(K_GCODE, 32'h400, "R5 cause via bit1");
    expect_out(K_STB, 0, "R8 strobe not yet");
    step();
    expect_out(K_STB, 1, "R8 strobe");
    expect_out(K_H0, 32'h1234, "R8 hold0");
    expect_out(K_H1, 32'hABCD, "R8 hold1");
    tmr0_count = 16'h5555; tmr1_count = 16'h6666;
    step();
    expect_out(K_STB, 0, "R8 strobe single");
    expect_out(K_H0, 32'h1234, "R8 hold0 kept");
    expect_out(K_H1, 32'hABCD, "R8 hold1 kept");
    step();

    // R6 DMA group
    dma_enable = 1'b1; dma_suspend = 8'd0;
    dma_req = 16'h0010; step(); dma_req = '0;
    rd(2'd2, 32'h0000_0010, "R1 dma status");
    expect_out(K_DCODE, 0, "R6 dma masked");
    step();
    wr(2'd2, 32'h0010_0000);
    rd(2'd2, 32'h0010_0010, "R4 dma mask");
    expect_out(K_DCODE, 32'h800, "R6 dma code");
    expect_out(K_DC, 1, "R6 dma cause");
    step();
    wr(2'd2, 32'h0000_0010);
    rd(2'd2, 32'h0010_0000, "R2 dma clear");
    expect_out(K_DCODE, 0, "R6 dma cleared");
    step();
    dma_req = 16'h8000; step(); dma_req = '0;
    expect_out(K_DCODE, 32'h800, "R6 unmaskable bit15");
    step();

    // R7 gating
    dma_enable = 1'b0; #0.5;
    expect_out(K_DCODE, 0, "R7 enable off");
    expect_out(K_DC, 0, "R7 enable off cause");
    step();
    dma_enable = 1'b1; dma_suspend = 8'd1; #0.5;
    expect_out(K_DCODE, 0, "R7 suspend one");
    step();
    dma_suspend = 8'd2; #0.5;
    expect_out(K_DCODE, 32'h800, "R7 suspend two");
    rd(2'd2, 32'h0010_8000, "R7 status retained");

    // R3 DMA
    dma_req = 16'h8000; reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 32'h0000_8000;
    step();
    dma_req = '0; reg_we = 1'b0; reg_wdata = '0;
    rd(2'd2, 32'h0010_8000, "R3 dma req wins");
    look("end");

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule